// File: doc/BRIEF.md
# Baud Divisor and Oversampling Search Engine

This block takes a source clock frequency and a requested baud rate, both as 32-bit unsigned numbers. For every supported oversampling ratio it works out an integer clock divisor. It compares that divisor with the next larger one and keeps the pair whose resulting baud rate lies closest to the request. At the end it reports the best ratio as a register-ready field, the 13-bit divisor split into a high and a low byte, a flag that asks the receiver to sample on both clock edges, and whether the residual error is small enough to accept.

A single iterative restoring divider is shared by all the quotients the search needs. The search runs for a few thousand cycles after a one-cycle `start` and ends with a one-cycle `done`. The operands are captured when the search starts. The result outputs hold their values from one `done` to the next.

Top module: `baud_srch`

## Requirements
- R1: Oversampling ratios 4 through 32 are each evaluated exactly once, in ascending order.
- R2: For ratio r the base divisor is srcClkHz / (baudRate × r) with truncation, and a zero quotient is replaced by 1.
- R3: For each ratio the baud error of divisor d and of d+1 is each taken as the absolute difference between srcClkHz / (r × divisor) (truncated) and baudRate. d+1 is chosen only when its error is strictly smaller.
- R4: The best error starts equal to baudRate. A ratio's candidate replaces the best when its error is less than or equal to the best so far, so on equal error the higher ratio wins.
- R5: `unsupported` is 1 when the best error is greater than (baudRate / 100) × 3 (truncated division). An error equal to that bound is accepted.
- R6: `osrField` (5 bits) equals the chosen ratio minus one.
- R7: `bothEdge` is 1 exactly when the chosen ratio is in 4..7.
- R8: The chosen divisor is reduced to its low 13 bits. `sbrLow` carries bits 7:0 of it and `sbrHigh` carries bits 12:8.
- R9: `done` is high for exactly one cycle per search. The result outputs keep their values until the next `done`. After reset, `done`, `busy` and all result outputs are 0.
- R10: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` seen while `busy` is high, including the `done` cycle, is ignored. Operand changes after the accepted `start` do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (accepted only while idle) |
| srcClkHz | input | 32 | Source clock frequency in Hz |
| baudRate | input | 32 | Requested baud rate, nonzero |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| osrField | output | 5 | Chosen oversampling ratio minus one |
| sbrHigh | output | 5 | Divisor bits 12:8 |
| sbrLow | output | 8 | Divisor bits 7:0 |
| bothEdge | output | 1 | Both-edge sampling required |
| unsupported | output | 1 | Best error exceeds the 3 % bound |

## Verification
The completion pulse and a new request can land in the same cycle. A `start` raised on the very cycle `done` is seen must be dropped, and so must a `start` with new operands in the middle of a search. The bench raises `start` at both moments. It then confirms that `busy` stays low after the done cycle and that the reported result matches the operands of the first request. The results are judged against a bench-side model of the search. Chosen operand sets force the tie rule, the forced-to-one divisor, both-edge selection, and both sides of the tolerance bound.

// File: rtl/baud_srch_pkg.sv
package baud_srch_pkg;

  typedef enum logic [1:0] {
    OP_DIV_Q   = 2'd0,
    OP_CALC_LO = 2'd1,
    OP_CALC_HI = 2'd2,
    OP_TOL     = 2'd3
  } divOp_e;

  typedef struct packed {
    logic   init;
    logic   divGo;
    divOp_e op;
    logic   capQuo;
    logic   evalStep;
    logic   capRes;
  } ctrlStrobe_t;

endpackage

// File: rtl/baud_srch_div.sv
module baud_srch_div #(
  parameter int DW = 32,
  parameter int VW = 39
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          done,
  output logic [DW-1:0] quotient
);
  localparam int CW = $clog2(DW + 1);

  logic [VW:0]   rem;
  logic [DW-1:0] quo;
  logic [VW-1:0] divQ;
  logic [CW-1:0] cnt;
  logic          busyQ;
  logic          doneQ;
  logic [VW:0]   shifted;
  logic          fits;

  always_comb begin
    shifted = {rem[VW-1:0], quo[DW-1]};
    fits    = shifted >= {1'b0, divQ};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rem   <= '0;
      quo   <= '0;
      divQ  <= '0;
      cnt   <= '0;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (go && !busyQ) begin
        rem   <= '0;
        quo   <= dividend;
        divQ  <= divisor;
        cnt   <= CW'(DW);
        busyQ <= 1'b1;
      end else if (busyQ) begin
        rem <= fits ? (shifted - {1'b0, divQ}) : shifted;
        quo <= {quo[DW-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  assign done     = doneQ;
  assign quotient = quo;

  // R2: a division is only launched when the divider is free
  p_go_idle_r2: assert property (@(posedge clk) disable iff (!rstN) go |-> !busyQ);
  // R2: each division completes with a single pulse
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rstN) doneQ |=> !doneQ);

endmodule

// File: rtl/baud_srch_ctrl.sv
module baud_srch_ctrl
  import baud_srch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        divDone,
  input  logic        lastRatio,
  output ctrlStrobe_t strb,
  output logic        busy,
  output logic        done
);
  typedef enum logic [2:0] {
    S_IDLE, S_LAUNCH, S_WAIT, S_EVAL, S_DONE
  } state_e;

  state_e state;
  divOp_e opQ;

  always_comb begin
    strb    = '0;
    strb.op = opQ;
    unique case (state)
      S_IDLE:   strb.init = start;
      S_LAUNCH: strb.divGo = 1'b1;
      S_WAIT: begin
        if (divDone) begin
          if (opQ == OP_TOL) strb.capRes = 1'b1;
          else               strb.capQuo = 1'b1;
        end
      end
      S_EVAL:   strb.evalStep = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      opQ   <= OP_DIV_Q;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state <= S_LAUNCH;
          opQ   <= OP_DIV_Q;
        end
        S_LAUNCH: state <= S_WAIT;
        S_WAIT: if (divDone) begin
          unique case (opQ)
            OP_DIV_Q:   begin opQ <= OP_CALC_LO; state <= S_LAUNCH; end
            OP_CALC_LO: begin opQ <= OP_CALC_HI; state <= S_LAUNCH; end
            OP_CALC_HI: state <= S_EVAL;
            default:    state <= S_DONE;
          endcase
        end
        S_EVAL: begin
          opQ   <= lastRatio ? OP_TOL : OP_DIV_Q;
          state <= S_LAUNCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R10: a search never restarts straight out of the done cycle
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rstN) done |=> !busy);

endmodule

// File: rtl/baud_srch_dp.sv
module baud_srch_dp
  import baud_srch_pkg::*;
#(
  parameter int DW       = 32,
  parameter int SBR_W    = 13,
  parameter int MIN_OSR  = 4,
  parameter int MAX_OSR  = 32,
  parameter int EDGE_MAX = 7,
  parameter int TOL_NUM  = 3,
  parameter int TOL_DEN  = 100,
  localparam int FW      = $clog2(MAX_OSR),
  localparam int RW      = $clog2(MAX_OSR + 1),
  localparam int VW      = DW + RW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [DW-1:0]    srcClk,
  input  logic [DW-1:0]    baud,
  output logic             divDone,
  output logic             lastRatio,
  output logic [FW-1:0]    osrField,
  output logic [SBR_W-9:0] sbrHigh,
  output logic [7:0]       sbrLow,
  output logic             bothEdge,
  output logic             unsupported
);
  logic [DW-1:0] clkQ, baudQ, q, calcLo, calcHi;
  logic [DW-1:0] bestErr, bestQ;
  logic [RW-1:0] ratio, bestRatio;
  logic [DW:0]   qInc;
  logic [DW-1:0] dend, quo;
  logic [VW-1:0] dsor;
  logic [DW-1:0] errLo, errHi, candErr, candQ, tolVal;
  logic          pickHi;

  always_comb begin
    qInc = {1'b0, q} + 1'b1;
    dend = clkQ;
    unique case (strb.op)
      OP_DIV_Q:   dsor = VW'(baudQ) * VW'(ratio);
      OP_CALC_LO: dsor = VW'(q) * VW'(ratio);
      OP_CALC_HI: dsor = VW'(qInc) * VW'(ratio);
      default: begin
        dend = baudQ;
        dsor = VW'(TOL_DEN);
      end
    endcase
    errLo   = (calcLo >= baudQ) ? (calcLo - baudQ) : (baudQ - calcLo);
    errHi   = (calcHi >= baudQ) ? (calcHi - baudQ) : (baudQ - calcHi);
    pickHi  = errLo > errHi;
    candErr = pickHi ? errHi : errLo;
    candQ   = pickHi ? qInc[DW-1:0] : q;
    tolVal  = quo * DW'(TOL_NUM);
  end

  assign lastRatio = (ratio == RW'(MAX_OSR));

  baud_srch_div #(.DW(DW), .VW(VW)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .go       (strb.divGo),
    .dividend (dend),
    .divisor  (dsor),
    .done     (divDone),
    .quotient (quo)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkQ        <= '0;
      baudQ       <= '0;
      q           <= '0;
      calcLo      <= '0;
      calcHi      <= '0;
      bestErr     <= '0;
      bestQ       <= '0;
      ratio       <= RW'(MIN_OSR);
      bestRatio   <= RW'(MIN_OSR);
      osrField    <= '0;
      sbrHigh     <= '0;
      sbrLow      <= '0;
      bothEdge    <= 1'b0;
      unsupported <= 1'b0;
    end else begin
      if (strb.init) begin
        clkQ      <= srcClk;
        baudQ     <= baud;
        ratio     <= RW'(MIN_OSR);
        bestErr   <= baud;
        bestQ     <= '0;
        bestRatio <= RW'(MIN_OSR);
      end
      if (strb.capQuo) begin
        unique case (strb.op)
          OP_DIV_Q:   q <= (quo == '0) ? DW'(1) : quo;
          OP_CALC_LO: calcLo <= quo;
          OP_CALC_HI: calcHi <= quo;
          default:    ;
        endcase
      end
      if (strb.evalStep) begin
        if (candErr <= bestErr) begin
          bestErr   <= candErr;
          bestQ     <= candQ;
          bestRatio <= ratio;
        end
        if (!lastRatio) ratio <= ratio + 1'b1;
      end
      if (strb.capRes) begin
        osrField    <= FW'(bestRatio - 1'b1);
        sbrHigh     <= bestQ[SBR_W-1:8];
        sbrLow      <= bestQ[7:0];
        bothEdge    <= (bestRatio >= RW'(MIN_OSR)) && (bestRatio <= RW'(EDGE_MAX));
        unsupported <= bestErr > tolVal;
      end
    end
  end

  // R1: the ratio under evaluation stays inside the supported range
  p_ratio_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.evalStep |-> (ratio >= RW'(MIN_OSR)) && (ratio <= RW'(MAX_OSR)));
  // R2: the divisor that is evaluated is never zero
  p_div_nonzero_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.evalStep |-> (q != '0));
  // R4: the best error never grows within a search
  p_best_monotone_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.evalStep |=> (bestErr <= $past(bestErr)));
  // R7: the edge flag agrees with the published ratio field
  p_edge_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.capRes |=> (bothEdge == (osrField < FW'(EDGE_MAX))));
  // R10: captured operands only change when a search is accepted
  p_operands_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.init |=> $stable(baudQ) && $stable(clkQ));

endmodule

// File: rtl/baud_srch.sv
module baud_srch
  import baud_srch_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SBR_W    = 13,
  parameter int MIN_OSR  = 4,
  parameter int MAX_OSR  = 32,
  parameter int EDGE_MAX = 7,
  localparam int FW      = $clog2(MAX_OSR)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] srcClkHz,
  input  logic [DATA_W-1:0] baudRate,
  output logic              busy,
  output logic              done,
  output logic [FW-1:0]     osrField,
  output logic [SBR_W-9:0]  sbrHigh,
  output logic [7:0]        sbrLow,
  output logic              bothEdge,
  output logic              unsupported
);
  ctrlStrobe_t strb;
  logic        divDone;
  logic        lastRatio;

  baud_srch_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .divDone   (divDone),
    .lastRatio (lastRatio),
    .strb      (strb),
    .busy      (busy),
    .done      (done)
  );

  baud_srch_dp #(
    .DW       (DATA_W),
    .SBR_W    (SBR_W),
    .MIN_OSR  (MIN_OSR),
    .MAX_OSR  (MAX_OSR),
    .EDGE_MAX (EDGE_MAX)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .srcClk      (srcClkHz),
    .baud        (baudRate),
    .divDone     (divDone),
    .lastRatio   (lastRatio),
    .osrField    (osrField),
    .sbrHigh     (sbrHigh),
    .sbrLow      (sbrLow),
    .bothEdge    (bothEdge),
    .unsupported (unsupported)
  );

endmodule

// File: tb/baud_srch_tb.sv
module baud_srch_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] srcClkHz = '0;
  logic [31:0] baudRate = '0;
  logic        busy, done, bothEdge, unsupported;
  logic [4:0]  osrField;
  logic [4:0]  sbrHigh;
  logic [7:0]  sbrLow;

  int nTests = 0;
  int nFail  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  baud_srch u_dut (
    .clk(clk), .rstN(rstN), .start(start), .srcClkHz(srcClkHz), .baudRate(baudRate),
    .busy(busy), .done(done), .osrField(osrField), .sbrHigh(sbrHigh), .sbrLow(sbrLow),
    .bothEdge(bothEdge), .unsupported(unsupported)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFail = nFail + 1;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nTests = nTests + 1;
    if (!ok) begin
      nFail = nFail + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Search model built from the requirements
  task automatic model(input longint unsigned c, input longint unsigned b,
                       output int fld, output int sbr, output bit be,
                       output bit bad, output longint unsigned errOut);
    longint unsigned best = b;
    longint unsigned bo = 4, bs = 0;
    for (longint unsigned r = 4; r <= 32; r++) begin
      longint unsigned q = c / (b * r);
      longint unsigned c1, c2, e1, e2, e;
      if (q == 0) q = 1;
      c1 = c / (r * q);
      c2 = c / (r * (q + 1));
      e1 = (c1 >= b) ? c1 - b : b - c1;
      e2 = (c2 >= b) ? c2 - b : b - c2;
      if (e1 > e2) begin q = q + 1; e = e2; end else e = e1;
      if (e <= best) begin best = e; bo = r; bs = q; end
    end
    fld    = int'(bo - 1) & 31;
    sbr    = int'(bs & 64'h1fff);
    be     = (bo >= 4) && (bo <= 7);
    bad    = best > ((b / 100) * 3);
    errOut = best;
  endtask

  task automatic launch(input logic [31:0] c, input logic [31:0] b);
    @(negedge clk);
    srcClkHz = c; baudRate = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 6000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R9", "done seen", done, 1);
  endtask

  task automatic checkModel(input string tag, input logic [31:0] c, input logic [31:0] b);
    int fld, sbr; bit be, bad; longint unsigned e;
    model(c, b, fld, sbr, be, bad, e);
    chk(osrField == fld, "R1 R6", {tag, " osrField"}, osrField, fld);
    chk({sbrHigh, sbrLow} == sbr, "R2 R3 R8", {tag, " divisor"}, {sbrHigh, sbrLow}, sbr);
    chk(bothEdge == be, "R7", {tag, " bothEdge"}, bothEdge, be);
    chk(unsupported == bad, "R5", {tag, " unsupported"}, unsupported, bad);
  endtask

  task automatic runCase(input string tag, input logic [31:0] c, input logic [31:0] b);
    launch(c, b);
    waitDone();
    checkModel(tag, c, b);
    @(negedge clk);
    chk(!done, "R9", {tag, " done one cycle"}, done, 0);
  endtask

  task automatic testReset();
    chk(!busy && !done, "R9", "reset busy/done", {busy, done}, 0);
    chk(osrField == 0 && sbrHigh == 0 && sbrLow == 0, "R9", "reset results", {osrField, sbrHigh, sbrLow}, 0);
    chk(!bothEdge && !unsupported, "R9", "reset flags", {bothEdge, unsupported}, 0);
  endtask

  task automatic testTie();
    // every ratio dividing 96 is exact; the highest such ratio (32) must win
    runCase("tie", 32'd96000, 32'd1000);
    chk(osrField == 5'd31, "R4", "tie picks highest ratio", osrField, 31);
    chk({sbrHigh, sbrLow} == 13'd3, "R4", "tie divisor", {sbrHigh, sbrLow}, 3);
  endtask

  task automatic testEdge();
    runCase("edge", 32'd7000, 32'd1000);
    chk(osrField == 5'd6, "R6", "ratio 7 field", osrField, 6);
    chk(bothEdge, "R7", "both-edge at ratio 7", bothEdge, 1);
    chk(!unsupported, "R5", "exact rate accepted", unsupported, 0);
  endtask

  task automatic testSlowClock();
    // quotient is zero for every ratio, forced to 1; error far beyond bound
    runCase("slow", 32'd1000, 32'd115200);
    chk({sbrHigh, sbrLow} != 0, "R2", "zero quotient forced", {sbrHigh, sbrLow}, 1);
    chk(unsupported, "R5", "slow clock rejected", unsupported, 1);
  endtask

  task automatic testTolerance();
    int fld, sbr; bit be, bad; longint unsigned e;
    int atBound = 0, overBound = 0;
    for (int c = 1000; c < 200000 && (atBound == 0 || overBound == 0); c++) begin
      model(longint'(c), 64'd1000, fld, sbr, be, bad, e);
      if (e == 30 && atBound == 0) atBound = c;
      if (e == 31 && overBound == 0) overBound = c;
    end
    chk(atBound != 0 && overBound != 0, "R5", "bound cases found", atBound, overBound);
    if (atBound != 0) begin
      runCase("atBound", atBound, 32'd1000);
      chk(!unsupported, "R5", "error equal to bound accepted", unsupported, 0);
    end
    if (overBound != 0) begin
      runCase("overBound", overBound, 32'd1000);
      chk(unsupported, "R5", "error above bound rejected", unsupported, 1);
    end
  endtask

  task automatic testIgnore();
    launch(32'd48000000, 32'd115200);
    repeat (50) @(negedge clk);
    chk(busy, "R10", "busy during search", busy, 1);
    srcClkHz = 32'd7000; baudRate = 32'd1000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    checkModel("ignoreMid", 32'd48000000, 32'd115200);
    // start colliding with the done cycle
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!busy, "R10", "start on done cycle ignored", busy, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R10", "still idle", {busy, done}, 0);
    checkModel("hold", 32'd48000000, 32'd115200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    runCase("48M/115200", 32'd48000000, 32'd115200);
    runCase("8M/9600", 32'd8000000, 32'd9600);
    runCase("20.97M/57600", 32'd20971520, 32'd57600);
    testTie();
    testEdge();
    testSlowClock();
    testTolerance();
    testIgnore();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule